// File: doc/BRIEF.md
# Single-Cycle Byte-Memory Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. In each cycle it puts the program counter on the instruction port and decodes the word that comes back. It reads two operands from a 32-entry register file and computes a result. By the next rising edge it commits the register write, the data-memory byte write and the new program counter. The instruction and data memories sit outside the core and answer combinationally, so a load returns its byte in the same cycle it is addressed.

The instruction set is small. It has nine register-to-register operations, add-immediate, branch-if-equal, a relative jump, load byte and store byte. Branch and jump targets are computed from the address of the branch or jump instruction itself, not from the address of the instruction after it. The jump is PC-relative rather than absolute.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. `dmem_we` stays low for as long as `rst` is high.
- R2: Any instruction other than a taken branch or a jump advances `imem_addr` by exactly 4. `imem_addr` is always word aligned.
- R3: Opcode 000000 is the register format. Its fields are: destination in bits [25:21], first source in bits [20:16], second source in bits [15:11], function code in bits [5:0]. Function codes: 0x20 add, 0x22 subtract, 0x24 multiply (low 32 bits), 0x28 AND, 0x29 OR.
- R4: Function 0x25 divides as unsigned and yields 0xFFFFFFFF when the divisor is zero. Function 0x34 writes 1 if the first source is less than the second as signed values, otherwise 0. Function 0x38 shifts left and 0x39 shifts right logically, both by the low 5 bits of the second source.
- R5: Opcode 100001 writes the register in bits [25:21] with the register in bits [20:16] plus the sign-extended 16-bit immediate in bits [15:0].
- R6: Opcode 000010 compares the registers in bits [25:21] and [20:16]. If they are equal, the next PC is the current PC plus the sign-extended immediate times 4. Otherwise the next PC is the current PC plus 4.
- R7: Opcode 000001 sets the next PC to the current PC plus the sign-extended 26-bit field in bits [25:0] times 4.
- R8: Opcode 100000 drives `dmem_addr` with the register in bits [20:16] plus the sign-extended immediate. It writes the register in bits [25:21] with `dmem_rdata` zero-extended to 32 bits.
- R9: Opcode 110000 drives the same address as R8 and raises `dmem_we`. It drives `dmem_wdata` with the low byte of the register in bits [25:21]. No other instruction raises `dmem_we`.
- R10: Register 0 reads as zero. Writes addressed to register 0 have no effect.
- R11: An opcode outside the list above, or a register-format instruction with a function code outside the list, writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for load and store |
| dmem_wdata | output | 8 | Byte to store |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 8 | Byte at `dmem_addr`, combinational |

## Verification
No register contents leave the core directly. A wrong register value therefore becomes visible only when a store places its low byte on `dmem_wdata`, when it forms a load or store address, or when it decides a branch. The reference program stores every computed result within a cycle or two of producing it. A corrupted result is therefore seen at the store port almost immediately. A wrong program-counter update shows up on `imem_addr` in the very next cycle, because the bench compares the PC against its model on every clock.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int SH_W   = $clog2(XLEN);
    localparam int BYTE_W = 8;

    typedef enum logic [5:0] {
        OP_REG  = 6'b000000,
        OP_JMP  = 6'b000001,
        OP_BEQ  = 6'b000010,
        OP_LB   = 6'b100000,
        OP_ADDI = 6'b100001,
        OP_SB   = 6'b110000
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_MUL = 6'h24,
        FN_DIV = 6'h25,
        FN_AND = 6'h28,
        FN_OR  = 6'h29,
        FN_SLT = 6'h34,
        FN_SHL = 6'h38,
        FN_SHR = 6'h39
    } funct_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_AND,
        ALU_OR, ALU_SLT, ALU_SHL, ALU_SHR
    } alu_op_e;

    typedef enum logic [1:0] { WB_NONE, WB_ALU, WB_MEM } wb_sel_e;
    typedef enum logic [1:0] { PC_SEQ, PC_BEQ, PC_JMP } pc_sel_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    src2_is_rt;
        wb_sel_e wb_sel;
        pc_sel_e pc_sel;
        logic    mem_we;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext26(input logic [25:0] v);
        return {{(XLEN-26){v[25]}}, v};
    endfunction

endpackage

// File: rtl/core_decoder.sv
module core_decoder
    import mini_core_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [5:0] op;
    logic [5:0] fn;

    assign op = instr[31:26];
    assign fn = instr[5:0];

    always_comb begin
        ctrl = '{alu_op: ALU_ADD, use_imm: 1'b0, src2_is_rt: 1'b0,
                 wb_sel: WB_NONE, pc_sel: PC_SEQ, mem_we: 1'b0};
        case (op)
            OP_REG: begin
                ctrl.src2_is_rt = 1'b1;
                ctrl.wb_sel     = WB_ALU;
                case (fn)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_MUL:  ctrl.alu_op = ALU_MUL;
                    FN_DIV:  ctrl.alu_op = ALU_DIV;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    FN_SHL:  ctrl.alu_op = ALU_SHL;
                    FN_SHR:  ctrl.alu_op = ALU_SHR;
                    default: ctrl.wb_sel = WB_NONE;
                endcase
            end
            OP_ADDI: begin
                ctrl.use_imm = 1'b1;
                ctrl.wb_sel  = WB_ALU;
            end
            OP_LB: begin
                ctrl.use_imm = 1'b1;
                ctrl.wb_sel  = WB_MEM;
            end
            OP_SB: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ:  ctrl.pc_sel = PC_BEQ;
            OP_JMP:  ctrl.pc_sel = PC_JMP;
            default: ;
        endcase
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import mini_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] ra_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [XLEN-1:0]   rd_a,
    output logic [XLEN-1:0]   rd_b,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/core_alu.sv
module core_alu
    import mini_core_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    logic [SH_W-1:0] sh;
    assign sh = b[SH_W-1:0];

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            ALU_DIV: y = (b == '0) ? '1 : a / b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = XLEN'($signed(a) < $signed(b));
            ALU_SHL: y = a << sh;
            ALU_SHR: y = a >> sh;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mini_core.sv
module mini_core
    import mini_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [7:0]  dmem_wdata,
    output logic        dmem_we,
    input  logic [7:0]  dmem_rdata
);
    logic [XLEN-1:0]   pc_q, pc_d;
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] f_dst, f_src1, f_src2;
    logic [XLEN-1:0]   rd_a, rd_b, imm_ext, alu_b, alu_y, wb_val;
    logic              rf_we;

    assign f_dst  = imem_data[25:21];
    assign f_src1 = imem_data[20:16];
    assign f_src2 = imem_data[15:11];
    assign imm_ext = sext16(imem_data[15:0]);

    core_decoder u_dec (.instr(imem_data), .ctrl(ctrl));

    // Port A: r2 field. Port B: r3 for register format, else r1 (beq, sb).
    core_regfile u_rf (
        .clk(clk), .rst(rst),
        .ra_a(f_src1),
        .ra_b(ctrl.src2_is_rt ? f_src2 : f_dst),
        .rd_a(rd_a), .rd_b(rd_b),
        .we(rf_we), .wa(f_dst), .wd(wb_val)
    );

    assign alu_b = ctrl.use_imm ? imm_ext : rd_b;

    core_alu u_alu (.op(ctrl.alu_op), .a(rd_a), .b(alu_b), .y(alu_y));

    always_comb begin
        case (ctrl.wb_sel)
            WB_MEM:  wb_val = {{(XLEN-BYTE_W){1'b0}}, dmem_rdata};
            default: wb_val = alu_y;
        endcase
    end
    assign rf_we = (ctrl.wb_sel != WB_NONE) && !rst;

    always_comb begin
        case (ctrl.pc_sel)
            PC_BEQ:  pc_d = (rd_a == rd_b) ? pc_q + (imm_ext << 2) : pc_q + 4;
            PC_JMP:  pc_d = pc_q + (sext26(imem_data[25:0]) << 2);
            default: pc_d = pc_q + 4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rd_b[BYTE_W-1:0];
    assign dmem_we    = ctrl.mem_we && !rst;
endmodule

// File: rtl/mini_core_checker.sv
module mini_core_checker
    import mini_core_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we
);
    logic [5:0] op;
    assign op = imem_data[31:26];

    assert_pc_reset_R1: assert property (@(posedge clk) rst |=> imem_addr == 32'd0);

    assert_no_store_in_reset_R1: assert property (@(posedge clk) rst |-> !dmem_we);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (op != OP_BEQ && op != OP_JMP) |=> imem_addr == $past(imem_addr) + 32'd4);

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);

    assert_jmp_target_R7: assert property (@(posedge clk) disable iff (rst)
        op == OP_JMP |=> imem_addr == $past(imem_addr) + (sext26($past(imem_data[25:0])) << 2));

    assert_store_only_sb_R9: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> op == OP_SB);
endmodule

bind mini_core mini_core_checker u_chk (
    .clk(clk), .rst(rst), .imem_addr(imem_addr),
    .imem_data(imem_data), .dmem_we(dmem_we)
);

// File: tb/tb_mini_core.sv
module tb_mini_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, dmem_addr;
    logic [31:0] imem_data;
    logic [7:0]  dmem_wdata, dmem_rdata;
    logic        dmem_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    logic [31:0] prog [64];
    logic [7:0]  dmem [256];

    assign imem_data  = prog[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

    mini_core dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata)
    );

    function automatic logic [31:0] enc_r(int d, int s1, int s2, logic [5:0] fn);
        return {6'b000000, 5'(d), 5'(s1), 5'(s2), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int a, int b, int imm);
        return {op, 5'(a), 5'(b), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int dest);
        return {6'b000001, 26'(dest)};
    endfunction

    // reference model state
    logic [31:0] m_reg [32];
    logic [7:0]  m_mem [256];
    logic [31:0] m_pc;

    function automatic string tag_of(logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        if (op == 6'b000000) begin
            if (fn == 6'h25 || fn == 6'h34 || fn == 6'h38 || fn == 6'h39) return "R4";
            if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h28 || fn == 6'h29)
                return (w[25:21] == 0) ? "R10" : "R3";
            return "R11";
        end
        if (op == 6'b100001) return (w[25:21] == 0) ? "R10" : "R5";
        if (op == 6'b000010) return "R6";
        if (op == 6'b000001) return "R7";
        if (op == 6'b100000) return "R8";
        if (op == 6'b110000) return (w[25:21] == 0) ? "R10" : "R9";
        return "R11";
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rr(logic [4:0] i);
        return (i == 0) ? 32'd0 : m_reg[i];
    endfunction

    string pc_tag = "R2";

    task automatic compare_and_step();
        logic [31:0] w = prog[m_pc[7:2]];
        logic [5:0]  op = w[31:26];
        logic [5:0]  fn = w[5:0];
        logic [4:0]  ra = w[25:21], rb = w[20:16], rc = w[15:11];
        logic [31:0] imm = {{16{w[15]}}, w[15:0]};
        logic [31:0] a = rr(rb), b = rr(rc), res = 0;
        logic        wr = 0;
        logic [31:0] nxt = m_pc + 4;
        logic [31:0] ea = a + imm;
        string t = tag_of(w);
        check(pc_tag, "pc", imem_addr, m_pc);
        check(t, "store strobe", {31'd0, dmem_we}, {31'd0, op == 6'b110000});
        if (op == 6'b110000) begin
            check(t, "store addr", dmem_addr, ea);
            check(t, "store byte", {24'd0, dmem_wdata}, {24'd0, rr(ra)[7:0]});
            m_mem[ea[7:0]] = rr(ra)[7:0];
        end else if (op == 6'b100000) begin
            check(t, "load addr", dmem_addr, ea);
            res = {24'd0, m_mem[ea[7:0]]}; wr = 1;
        end else if (op == 6'b100001) begin
            res = a + imm; wr = 1;
        end else if (op == 6'b000000) begin
            wr = 1;
            case (fn)
                6'h20: res = a + b;
                6'h22: res = a - b;
                6'h24: res = a * b;
                6'h25: res = (b == 0) ? 32'hFFFF_FFFF : a / b;
                6'h28: res = a & b;
                6'h29: res = a | b;
                6'h34: res = ($signed(a) < $signed(b)) ? 1 : 0;
                6'h38: res = a << b[4:0];
                6'h39: res = a >> b[4:0];
                default: wr = 0;
            endcase
        end else if (op == 6'b000010) begin
            if (rr(ra) == rr(rb)) nxt = m_pc + (imm << 2);
        end else if (op == 6'b000001) begin
            nxt = m_pc + ({{6{w[25]}}, w[25:0]} << 2);
        end
        if (wr && ra != 0) m_reg[ra] = res;
        pc_tag = (op == 6'b000010) ? "R6" : (op == 6'b000001) ? "R7" : "R2";
        m_pc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;  // funct 0: unknown, R11
        for (int i = 0; i < 256; i++) begin dmem[i] = 8'd0; m_mem[i] = 8'd0; end
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        prog[0]  = enc_i(6'b100001, 1, 0, 7);
        prog[1]  = enc_i(6'b100001, 2, 0, -3);
        prog[2]  = enc_r(3, 1, 2, 6'h20);
        prog[3]  = enc_i(6'b110000, 3, 0, 0);
        prog[4]  = enc_r(4, 1, 2, 6'h22);
        prog[5]  = enc_i(6'b110000, 4, 0, 1);
        prog[6]  = enc_r(5, 1, 2, 6'h24);
        prog[7]  = enc_i(6'b110000, 5, 0, 2);
        prog[8]  = enc_r(6, 4, 1, 6'h25);
        prog[9]  = enc_i(6'b110000, 6, 0, 3);
        prog[10] = enc_r(7, 1, 0, 6'h25);
        prog[11] = enc_i(6'b110000, 7, 0, 4);
        prog[12] = enc_r(8, 1, 2, 6'h28);
        prog[13] = enc_r(9, 1, 2, 6'h29);
        prog[14] = enc_i(6'b110000, 8, 0, 5);
        prog[15] = enc_i(6'b110000, 9, 0, 6);
        prog[16] = enc_r(10, 2, 1, 6'h34);
        prog[17] = enc_i(6'b110000, 10, 0, 7);
        prog[18] = enc_i(6'b100001, 11, 0, 35);
        prog[19] = enc_r(12, 1, 11, 6'h38);
        prog[20] = enc_i(6'b110000, 12, 0, 8);
        prog[21] = enc_r(13, 2, 1, 6'h39);
        prog[22] = enc_i(6'b110000, 13, 0, 9);
        prog[23] = enc_i(6'b100001, 0, 0, 5);
        prog[24] = enc_i(6'b110000, 0, 0, 10);
        prog[25] = 32'hFC22_0000;
        prog[26] = enc_r(1, 2, 2, 6'h3F);
        prog[27] = enc_i(6'b110000, 1, 0, 11);
        prog[28] = enc_i(6'b100001, 15, 0, 16'h01F0);
        prog[29] = enc_i(6'b110000, 15, 0, 16'h20);
        prog[30] = enc_i(6'b100000, 16, 0, 16'h20);
        prog[31] = enc_i(6'b100001, 17, 0, 4);
        prog[32] = enc_r(18, 16, 17, 6'h39);
        prog[33] = enc_i(6'b110000, 18, 0, 12);
        prog[34] = enc_i(6'b100001, 19, 0, 16'h30);
        prog[35] = enc_i(6'b100000, 20, 19, -16);
        prog[36] = enc_i(6'b110000, 20, 19, -15);
        prog[37] = enc_i(6'b000010, 1, 2, 5);
        prog[38] = enc_i(6'b000010, 1, 1, 2);
        prog[39] = enc_i(6'b110000, 1, 0, 13);
        prog[40] = enc_i(6'b100001, 21, 0, 3);
        prog[41] = enc_i(6'b100001, 22, 22, 1);
        prog[42] = enc_i(6'b000010, 22, 21, 2);
        prog[43] = enc_j(-2);
        prog[44] = enc_i(6'b110000, 22, 0, 14);
        prog[45] = enc_j(2);
        prog[46] = enc_i(6'b110000, 1, 0, 15);
        prog[47] = enc_i(6'b110000, 22, 0, 16);
        prog[48] = enc_j(0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "pc in reset", imem_addr, 32'd0);
        check("R1", "strobe in reset", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        m_pc = 32'd0;
        for (int c = 0; c < 90; c++) begin
            #1;
            compare_and_step();
            @(negedge clk);
        end
        // final memory image through the store port's effect (R9, R8)
        for (int i = 0; i < 256; i++) begin
            if (dmem[i] !== m_mem[i]) check("R9", "memory image", {24'd0, dmem[i]}, {24'd0, m_mem[i]});
        end
        check("R8", "zero-extended load shifted", {24'd0, dmem[12]}, 32'h0000_000F);
        check("R10", "r0 stored as zero", {24'd0, dmem[10]}, 32'd0);
        check("R11", "unknown ops left r1", {24'd0, dmem[11]}, 32'h0000_0007);
        check("R7", "loop count", {24'd0, dmem[14]}, 32'h0000_0003);
        check("R4", "divide by zero", {24'd0, dmem[4]}, 32'h0000_00FF);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule